// File: doc/BRIEF.md
# Flip Buffer Index Tracker

This block keeps the three small counters that steer triple-buffered display flipping in a 3D engine. These are a producer (write) index, a consumer (read) index and a wrap modulo, all held in one surface control word. The engine's command stream updates the word through methods. Methods can load any field or step the write index forward with wrap-around. The display side steps the read index through a register-bus write to a separate kick register.

A flip-stall method holds the command stream until the consumer catches up. After the stall is accepted, the method port drops ready. It raises ready again once the read index equals the write index. The pending stall is reported on its own output. Software can read the surface word back, and can also overwrite it whole.

Top module: `flip_index_tracker`

## Requirements
- R1: After reset, all three fields read as zero, `mth_ready` is 1 and `flip_stalled` is 0.
- R2: A method is accepted when `mth_valid` and `mth_ready` are both 1. Method code 0x124 loads the write index, 0x120 loads the read index and 0x128 loads the modulo. Each load takes the low IDX_W bits of `mth_param`.
- R3: Method code 0x12C sets the write index to (write + 1) mod modulo. The full remainder is used even when the index is already at or above the modulo (for example 6 with modulo 3 gives 1).
- R4: A register write to offset 0x71C with data bit 1 set sets the read index to (read + 1) mod modulo. Data bit 0 alone leaves the read index unchanged.
- R5: When the modulo field is zero, both increments leave their index unchanged.
- R6: One cycle after a stall method (code 0x130) is accepted, `mth_ready` is 0 and `flip_stalled` is 1. They stay that way while the read and write indices differ.
- R7: `mth_ready` returns to 1, and `flip_stalled` to 0, one cycle after the first stalled cycle in which the read index equals the write index. A stall issued with equal indices therefore drops ready for exactly one cycle.
- R8: `reg_rdata` at offset 0x710 shows the write index in bits 22:20, the read index in bits 26:24 and the modulo in bits 30:28, with every other bit zero. Any other offset reads zero.
- R9: A register write to offset 0x710 loads all three fields from those bit positions. A method that changes a field in the same cycle wins for that field.
- R10: A write-index increment method and a read-index kick in the same cycle both take effect. A read-index load method in the same cycle as a kick wins over the kick.
- R11: Any other method code is accepted and changes no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mth_valid | input | 1 | Method present |
| mth_ready | output | 1 | Method port can accept |
| mth_code | input | MTH_W | Method code |
| mth_param | input | DATA_W | Method parameter |
| reg_wr | input | 1 | Register-bus write strobe |
| reg_addr | input | ADDR_W | Register offset for write and readback |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Combinational readback of `reg_addr` |
| flip_stalled | output | 1 | A flip stall is pending |

## Verification
The hardest situation to reach is the stall release, where the read index is kicked onto the write index while ready is already low. The bench makes the indices differ by two and issues the stall. It then kicks the read index one step at a time and checks the handshake in every cycle. This shows that ready stays low in the cycle where the indices first match and comes back exactly one cycle later. The bench also drives both ports in the same cycle to reach the cases that only occur together: a method increment with a kick, a method load with a kick, and a method load with a full-word overwrite.

// File: rtl/flip_pkg.sv
package flip_pkg;

   // Method codes (command-stream offsets)
   localparam int unsigned MC_LD_RD  = 'h120;
   localparam int unsigned MC_LD_WR  = 'h124;
   localparam int unsigned MC_LD_MOD = 'h128;
   localparam int unsigned MC_INC_WR = 'h12C;
   localparam int unsigned MC_STALL  = 'h130;

   // Register-bus offsets
   localparam int unsigned RO_SURF   = 'h710;
   localparam int unsigned RO_KICK   = 'h71C;

   // Field placement inside the surface word
   localparam int unsigned WR_LSB    = 20;
   localparam int unsigned RD_LSB    = 24;
   localparam int unsigned MOD_LSB   = 28;
   localparam int unsigned KICK_BIT  = 1;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_LD_RD,
      OP_LD_WR,
      OP_LD_MOD,
      OP_INC_WR,
      OP_STALL
   } flip_op_e;

endpackage

// File: rtl/flip_wrap_incr.sv
module flip_wrap_incr #(
   parameter int unsigned IDX_W       = 3,
   parameter bit          USE_DIVIDER = 1'b1
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [IDX_W-1:0] modulo,
   output logic [IDX_W-1:0] nxt
);

   localparam int unsigned STEPS = 1 << IDX_W;

   logic [IDX_W:0] sum;
   logic [IDX_W:0] divisor;

   assign sum     = {1'b0, idx} + (IDX_W+1)'(1);
   assign divisor = {1'b0, modulo};

   generate
      if (USE_DIVIDER) begin : g_div
         always_comb begin
            if (modulo == '0) nxt = idx;
            else              nxt = IDX_W'(sum % divisor);
         end
      end else begin : g_sub
         logic [IDX_W:0] acc;
         always_comb begin
            acc = sum;
            for (int k = 0; k < STEPS; k++) begin
               if (acc >= divisor) acc = acc - divisor;
            end
            if (modulo == '0) nxt = idx;
            else              nxt = IDX_W'(acc);
         end
      end
   endgenerate

endmodule

// File: rtl/flip_field_regs.sv
module flip_field_regs #(
   parameter int unsigned IDX_W       = 3,
   parameter bit          USE_DIVIDER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_rd,
   input  logic             ld_wr,
   input  logic             ld_mod,
   input  logic             inc_wr,
   input  logic             inc_rd,
   input  logic [IDX_W-1:0] param_idx,
   input  logic             sw_ld,
   input  logic [IDX_W-1:0] sw_wr,
   input  logic [IDX_W-1:0] sw_rd,
   input  logic [IDX_W-1:0] sw_mod,
   output logic [IDX_W-1:0] wr_idx,
   output logic [IDX_W-1:0] rd_idx,
   output logic [IDX_W-1:0] mod_val
);

   logic [IDX_W-1:0] wr_q, rd_q, mod_q;
   logic [IDX_W-1:0] wr_step, rd_step;

   flip_wrap_incr #(.IDX_W(IDX_W), .USE_DIVIDER(USE_DIVIDER)) u_wr_step (
      .idx(wr_q), .modulo(mod_q), .nxt(wr_step)
   );

   flip_wrap_incr #(.IDX_W(IDX_W), .USE_DIVIDER(USE_DIVIDER)) u_rd_step (
      .idx(rd_q), .modulo(mod_q), .nxt(rd_step)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         mod_q <= '0;
      end else begin
         if (ld_mod)      mod_q <= param_idx;
         else if (sw_ld)  mod_q <= sw_mod;

         if (ld_wr)       wr_q <= param_idx;
         else if (inc_wr) wr_q <= wr_step;
         else if (sw_ld)  wr_q <= sw_wr;

         if (ld_rd)       rd_q <= param_idx;
         else if (sw_ld)  rd_q <= sw_rd;
         else if (inc_rd) rd_q <= rd_step;
      end
   end

   assign wr_idx  = wr_q;
   assign rd_idx  = rd_q;
   assign mod_val = mod_q;

   // R3: write index advances by modular arithmetic
   a_r3_wr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_wr && mod_q != '0) |=>
      ({1'b0, wr_q} == ({1'b0, $past(wr_q)} + (IDX_W+1)'(1)) % {1'b0, $past(mod_q)}));

   // R4: read index kick advances by modular arithmetic
   a_r4_rd_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_rd && !ld_rd && !sw_ld && mod_q != '0) |=>
      ({1'b0, rd_q} == ({1'b0, $past(rd_q)} + (IDX_W+1)'(1)) % {1'b0, $past(mod_q)}));

   // R5: zero modulo freezes the index being stepped
   a_r5_zero_mod_wr: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_wr && mod_q == '0) |=> $stable(wr_q));

   a_r5_zero_mod_rd: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_rd && !ld_rd && !sw_ld && mod_q == '0) |=> $stable(rd_q));

endmodule

// File: rtl/flip_stall_ctl.sv
module flip_stall_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic stall_take,
   input  logic idx_match,
   output logic stalled
);

   logic stall_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     stall_q <= 1'b0;
      else if (stall_take)            stall_q <= 1'b1;
      else if (stall_q && idx_match)  stall_q <= 1'b0;
   end

   assign stalled = stall_q;

   // R6: stall holds while indices differ
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_q && !idx_match) |=> stall_q);

   // R7: a match releases the stall on the following edge
   a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_q && idx_match) |=> !stall_q);

endmodule

// File: rtl/flip_index_tracker.sv
module flip_index_tracker #(
   parameter int unsigned IDX_W       = 3,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned MTH_W       = 12,
   parameter bit          USE_DIVIDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mth_valid,
   output logic              mth_ready,
   input  logic [MTH_W-1:0]  mth_code,
   input  logic [DATA_W-1:0] mth_param,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              flip_stalled
);

   import flip_pkg::*;

   localparam int unsigned FIELD_TOP = MOD_LSB + IDX_W;

   generate
      if (IDX_W < 1 || IDX_W > 4) begin : g_bad_idx
         $error("flip_index_tracker: IDX_W must lie in 1..4");
      end
      if (DATA_W < FIELD_TOP) begin : g_bad_data
         $error("flip_index_tracker: DATA_W too narrow for surface fields");
      end
      if (ADDR_W < 11) begin : g_bad_addr
         $error("flip_index_tracker: ADDR_W too narrow for offsets");
      end
      if (MTH_W < 9) begin : g_bad_mth
         $error("flip_index_tracker: MTH_W too narrow for method codes");
      end
   endgenerate

   flip_op_e         op;
   logic             take;
   logic             stalled;
   logic [IDX_W-1:0] wr_idx, rd_idx, mod_val;
   logic             sw_ld, kick;

   always_comb begin
      op = OP_NONE;
      if (mth_code == MTH_W'(MC_LD_RD))       op = OP_LD_RD;
      else if (mth_code == MTH_W'(MC_LD_WR))  op = OP_LD_WR;
      else if (mth_code == MTH_W'(MC_LD_MOD)) op = OP_LD_MOD;
      else if (mth_code == MTH_W'(MC_INC_WR)) op = OP_INC_WR;
      else if (mth_code == MTH_W'(MC_STALL))  op = OP_STALL;
   end

   assign mth_ready = !stalled;
   assign take      = mth_valid && mth_ready;
   assign sw_ld     = reg_wr && (reg_addr == ADDR_W'(RO_SURF));
   assign kick      = reg_wr && (reg_addr == ADDR_W'(RO_KICK)) && reg_wdata[KICK_BIT];

   flip_field_regs #(.IDX_W(IDX_W), .USE_DIVIDER(USE_DIVIDER)) u_fields (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_rd     (take && op == OP_LD_RD),
      .ld_wr     (take && op == OP_LD_WR),
      .ld_mod    (take && op == OP_LD_MOD),
      .inc_wr    (take && op == OP_INC_WR),
      .inc_rd    (kick),
      .param_idx (mth_param[IDX_W-1:0]),
      .sw_ld     (sw_ld),
      .sw_wr     (reg_wdata[WR_LSB +: IDX_W]),
      .sw_rd     (reg_wdata[RD_LSB +: IDX_W]),
      .sw_mod    (reg_wdata[MOD_LSB +: IDX_W]),
      .wr_idx    (wr_idx),
      .rd_idx    (rd_idx),
      .mod_val   (mod_val)
   );

   flip_stall_ctl u_stall (
      .clk        (clk),
      .rst_n      (rst_n),
      .stall_take (take && op == OP_STALL),
      .idx_match  (rd_idx == wr_idx),
      .stalled    (stalled)
   );

   assign flip_stalled = stalled;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(RO_SURF)) begin
         reg_rdata[WR_LSB  +: IDX_W] = wr_idx;
         reg_rdata[RD_LSB  +: IDX_W] = rd_idx;
         reg_rdata[MOD_LSB +: IDX_W] = mod_val;
      end
   end

   logic unused_bits;
   assign unused_bits = ^{mth_param[DATA_W-1:IDX_W], reg_wdata};

   // R6: an accepted stall drops ready on the next cycle
   a_r6_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (take && op == OP_STALL) |=> (!mth_ready && flip_stalled));

   // R8: readback carries nothing outside the three fields
   a_r8_readback_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(RO_SURF)) |->
      ((reg_rdata & ~(DATA_W'({IDX_W{1'b1}}) << WR_LSB)
                  & ~(DATA_W'({IDX_W{1'b1}}) << RD_LSB)
                  & ~(DATA_W'({IDX_W{1'b1}}) << MOD_LSB)) == '0));

   // R8: any other offset reads zero
   a_r8_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr != ADDR_W'(RO_SURF)) |-> (reg_rdata == '0));

endmodule

// File: tb/flip_index_tracker_tb_top.sv
module flip_index_tracker_tb_top;

   localparam int IDX_W  = 3;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 12;
   localparam int MTH_W  = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mth_valid = 1'b0;
   logic              mth_ready;
   logic [MTH_W-1:0]  mth_code = '0;
   logic [DATA_W-1:0] mth_param = '0;
   logic              reg_wr = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic              flip_stalled;

   always #2.5 clk = ~clk;

   flip_index_tracker #(.IDX_W(IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MTH_W(MTH_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .mth_valid(mth_valid), .mth_ready(mth_ready),
      .mth_code(mth_code), .mth_param(mth_param), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flip_stalled(flip_stalled)
   );

   typedef struct {
      int          kind;   // 0: readback, 1: {stalled, ready}
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb_q[$];
   int    n_vec = 0;
   int    n_bad = 0;
   logic  chk = 1'b0;
   logic  done = 1'b0;

   int m_wr = 0, m_rd = 0, m_mod = 0;

   function automatic int step(int idx, int md);
      return (md == 0) ? idx : (idx + 1) % md;
   endfunction

   function automatic logic [31:0] surf_word();
      return (32'(m_mod) << 28) | (32'(m_rd) << 24) | (32'(m_wr) << 20);
   endfunction

   // Monitor: pops expectations and compares mid-cycle
   always @(negedge clk) begin
      if (chk && sb_q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it  = sb_q.pop_front();
         act = (it.kind == 0) ? reg_rdata : {30'd0, flip_stalled, mth_ready};
         n_vec++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
         end
      end
   end

   task automatic check_read(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
      item_t it;
      it.kind = 0; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      reg_addr = a; chk = 1'b1;
      @(posedge clk); #1;
      chk = 1'b0; reg_addr = '0;
   endtask

   task automatic check_surf(input string tag);
      check_read(ADDR_W'('h710), surf_word(), tag);
   endtask

   task automatic check_hs(input logic [1:0] e, input string tag);
      item_t it;
      it.kind = 1; it.exp = {30'd0, e}; it.tag = tag;
      sb_q.push_back(it);
      chk = 1'b1;
      @(posedge clk); #1;
      chk = 1'b0;
   endtask

   // Model of one cycle with an optional method and an optional register write
   task automatic model_apply(input bit mv, input int code, input int prm,
                              input bit rv, input int addr, input int data);
      int owr, ord, omod;
      owr = m_wr; ord = m_rd; omod = m_mod;
      if (rv && addr == 'h710) begin
         m_wr = (data >> 20) & 7; m_rd = (data >> 24) & 7; m_mod = (data >> 28) & 7;
      end
      if (rv && addr == 'h71C && data[1]) m_rd = step(ord, omod);
      if (mv) begin
         case (code)
            'h120: m_rd  = prm & 7;
            'h124: m_wr  = prm & 7;
            'h128: m_mod = prm & 7;
            'h12C: m_wr  = step(owr, omod);
            default: ;
         endcase
      end
   endtask

   // Driver: one cycle with method and/or register write, waiting for ready if a method is sent
   task automatic drive(input bit mv, input int code, input int prm,
                        input bit rv, input int addr, input int data);
      logic r;
      mth_valid = mv; mth_code = MTH_W'(code); mth_param = DATA_W'(prm);
      reg_wr = rv; reg_addr = ADDR_W'(addr); reg_wdata = DATA_W'(data);
      forever begin
         @(negedge clk); r = mth_ready;
         @(posedge clk); #1;
         reg_wr = 1'b0;
         if (r || !mv) break;
      end
      mth_valid = 1'b0; reg_addr = '0;
      model_apply(mv, code, prm, rv, addr, data);
   endtask

   task automatic meth(input int code, input int prm);
      drive(1'b1, code, prm, 1'b0, 0, 0);
   endtask

   task automatic rwr(input int addr, input int data);
      drive(1'b0, 0, 0, 1'b1, addr, data);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1: reset state
      check_surf("R1 reset fields");
      check_hs(2'b01, "R1 reset handshake");

      // R2: field loads from low parameter bits
      meth('h128, 'hF5);
      meth('h124, 'h3);
      meth('h120, 'hA);
      check_surf("R2 loads");

      // R3: write index wraps
      meth('h12C, 0); check_surf("R3 inc 3->4");
      meth('h12C, 0); check_surf("R3 inc 4->0");
      meth('h128, 3); meth('h124, 6);
      meth('h12C, 0); check_surf("R3 index above modulo");

      // R4: read index kick and blit bit
      rwr('h71C, 2); check_surf("R4 kick");
      rwr('h71C, 1); check_surf("R4 blit bit ignored");
      rwr('h71C, 3); check_surf("R4 kick with both bits");

      // R5: zero modulo
      meth('h128, 0);
      meth('h12C, 0); check_surf("R5 write inc at zero modulo");
      rwr('h71C, 2);  check_surf("R5 read kick at zero modulo");

      // R8: readback of other offsets
      check_read(ADDR_W'('h71C), 32'h0, "R8 other offset reads zero");

      // R9: full-word overwrite
      rwr('h710, 'hFFFF_FFFF); check_surf("R9 overwrite all fields");
      rwr('h710, 'h5A3B_1C2D); check_surf("R9 overwrite pattern");
      drive(1'b1, 'h124, 1, 1'b1, 'h710, 'h7460_0000);
      check_surf("R9 method wins over overwrite");

      // R10: simultaneous updates
      meth('h128, 7); meth('h124, 3); meth('h120, 5);
      drive(1'b1, 'h12C, 0, 1'b1, 'h71C, 2);
      check_surf("R10 both increments");
      drive(1'b1, 'h120, 2, 1'b1, 'h71C, 2);
      check_surf("R10 load beats kick");

      // R11: unrelated method code
      meth('h100, 'hFFFF_FFFF);
      check_surf("R11 no-op method");
      check_hs(2'b01, "R11 ready kept");

      // R6/R7: stall with differing indices
      meth('h128, 3); meth('h124, 2); meth('h120, 0);
      meth('h130, 0);
      check_hs(2'b10, "R6 stall raised");
      check_hs(2'b10, "R6 stall held");
      rwr('h71C, 2);
      check_hs(2'b10, "R6 stall held after one kick");
      rwr('h71C, 2);
      check_hs(2'b10, "R7 still low in matching cycle");
      check_hs(2'b01, "R7 ready back one cycle later");
      check_surf("R7 indices after release");

      // R7: stall with equal indices drops ready for one cycle
      meth('h130, 0);
      check_hs(2'b10, "R7 equal-index stall one cycle");
      check_hs(2'b01, "R7 equal-index release");
      meth('h12C, 0);
      check_surf("R2 method after stall");

      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule